// File: doc/BRIEF.md
# Command-Byte Control Register Bank with Serial Write Port

This block is a write-only slave on a two-wire serial bus (I2C) that holds every control setting of an audio signal path: input attenuation, bass and treble, left and right output level, microphone routing, gain and level, and a set of general mode bits. The host addresses the block once after a START condition. It may then stream any number of data bytes before the STOP. Each byte names its own destination in its three most significant bits, so no pointer or sub-address byte is used. Each byte is decoded and applied when it completes.

Both bus lines are oversampled on a fast system clock. Each line passes through a two-stage synchronizer and a persistence filter. START, STOP and every bit are then detected from the filtered copies. The slave's only drive onto the bus is an open-drain pull-low request used for acknowledges. Codes with no defined meaning are acknowledged like any other byte, but they can never leave an undefined setting in a register. The reset input is active high and asynchronous.

Top module: `cmdbyte_ctl`

## Requirements
- R1: The slave acknowledges an address byte equal to {5'b10000, strap_a2_i, strap_a1_i, 1'b0}, sent MSB first. For any other address it gives no acknowledge, and the data bytes that follow are ignored until the next START.
- R2: An address byte with the matching 7-bit address but bit 0 (read/write) at 1 is not acknowledged, and bytes that follow it change no register.
- R3: For an accepted address or data byte, the bus line is held low for the whole high phase of the ninth SCL pulse. sda_pull_o changes only while the filtered SCL is low, and it is released after the ninth pulse.
- R4: After reset the outputs are: atten_o 0, bass_o and treble_o 6 (flat), vol_l_o and vol_r_o 31, mute_l_o and mute_r_o 1, mic_sel_o 00, mic_gain_o 10, mic_vol_o 21, mic_mute_o 1, and all five general bits 0.
- R5: Data byte bits 7:5 select the register: 0 attenuation, 1 bass, 2 treble, 3 right level, 4 left level, 5 mic select and gain, 6 mic level, 7 general. A byte changes no other register, and registers change only when a data byte completes.
- R6: After a single address phase, every data byte up to the STOP is acknowledged and applied in turn.
- R7: Attenuation takes bits 2:0 of its byte (2 dB per step). Bits 4:3 are ignored.
- R8: Bass and treble take bits 3:0 when the code is 0 to 12. Codes 13 to 15 are acknowledged, but the register keeps its value.
- R9: Left and right levels take bits 4:0. mute_l_o and mute_r_o are 1 exactly when the matching level code is 31.
- R10: Mic level takes bits 4:0, and a code above 21 is stored as 21. mic_mute_o is 1 exactly when the stored code is 21.
- R11: The mic register takes select from bits 3:2 (00 input 1, 01 input 2, 1x both) and gain from bits 1:0 (00 +0 dB, 01 +20 dB, 10 +30 dB). A byte whose gain code is 11 is acknowledged but changes neither field.
- R12: The general byte maps bit 0 to shutdown_o, bit 1 to gpo_o, bit 2 to enhance_o, bit 3 to mono_o and bit 4 to ext_loop_o.
- R13: A pulse on SDA or SCL that lasts fewer than FILT_LEN system clocks is not seen: it starts no START or STOP and causes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Asynchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 requests the data line be pulled low |
| strap_a2_i | input | 1 | Address strap, address bit 2 |
| strap_a1_i | input | 1 | Address strap, address bit 1 |
| atten_o | output | 3 | Input attenuation code |
| bass_o | output | 4 | Bass code, 6 is flat |
| treble_o | output | 4 | Treble code, 6 is flat |
| vol_l_o | output | 5 | Left output level code |
| vol_r_o | output | 5 | Right output level code |
| mute_l_o | output | 1 | Left output muted |
| mute_r_o | output | 1 | Right output muted |
| mic_sel_o | output | 2 | Microphone input select |
| mic_gain_o | output | 2 | Microphone preamp gain |
| mic_vol_o | output | 5 | Microphone level code |
| mic_mute_o | output | 1 | Microphone muted |
| shutdown_o | output | 1 | Shutdown request |
| gpo_o | output | 1 | General-purpose output level |
| enhance_o | output | 1 | Stereo enhance on |
| mono_o | output | 1 | Mono force on |
| ext_loop_o | output | 1 | External loop enabled |

## Verification
A register field is updated on the system clock edge that follows the filtered SCL falling edge at the end of bit eight. This is about SYNC_STAGES + FILT_LEN + 2 clocks after the raw line falls. The acknowledge pull is raised at that same edge, and it drops the same number of clocks after the ninth pulse falls. The bench holds every bus phase for 20 clocks, well beyond this latency. It samples the data line twice inside each ninth high phase, and it reads the register outputs only after the STOP has settled, so each value is observed after it is due and before any later byte can change it.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int SEL_W     = 3;
    localparam int BITCNT_W  = 4;
    localparam logic [4:0] ADDR_FIXED = 5'b10000;
    localparam logic [3:0] TONE_FLAT  = 4'd6;
    localparam logic [3:0] TONE_MAX   = 4'd12;
    localparam logic [4:0] VOL_MUTE   = 5'd31;
    localparam logic [4:0] MIC_MUTE   = 5'd21;
    localparam logic [1:0] GAIN_30DB  = 2'b10;
    localparam logic [1:0] GAIN_BAD   = 2'b11;

    typedef enum logic [SEL_W-1:0] {
        SEL_ATTEN   = 3'd0,
        SEL_BASS    = 3'd1,
        SEL_TREBLE  = 3'd2,
        SEL_VOL_R   = 3'd3,
        SEL_VOL_L   = 3'd4,
        SEL_MIC_CFG = 3'd5,
        SEL_MIC_VOL = 3'd6,
        SEL_GENERAL = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic ext_loop;
        logic mono;
        logic enhance;
        logic gpo;
        logic shutdown;
    } gen_t;

    typedef struct packed {
        logic [2:0] atten;
        logic [3:0] bass;
        logic [3:0] treble;
        logic [4:0] vol_r;
        logic [4:0] vol_l;
        logic [1:0] mic_sel;
        logic [1:0] mic_gain;
        logic [4:0] mic_vol;
        gen_t       gen;
    } regs_t;

    function automatic regs_t regs_default();
        regs_t r;
        r.atten    = '0;
        r.bass     = TONE_FLAT;
        r.treble   = TONE_FLAT;
        r.vol_r    = VOL_MUTE;
        r.vol_l    = VOL_MUTE;
        r.mic_sel  = 2'b00;
        r.mic_gain = GAIN_30DB;
        r.mic_vol  = MIC_MUTE;
        r.gen      = '0;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] write_addr(input logic a2, input logic a1);
        return {ADDR_FIXED, a2, a1, 1'b0};
    endfunction

    function automatic logic tone_ok(input logic [3:0] code);
        return code <= TONE_MAX;
    endfunction
endpackage

// File: rtl/ctl_bus_filter.sv
module ctl_bus_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sync_q <= '1;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            if (synced == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                dout  <= synced;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctl_i2c_rx.sv
module ctl_i2c_rx
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] own_addr,
    output logic              sda_pull,
    output logic              byte_v,
    output logic [BYTE_W-1:0] byte_d
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] ACK_BIT  = BITCNT_W'(BYTE_W + 1);

    logic                scl_q, sda_q;
    phase_e              ph_q;
    logic [BITCNT_W-1:0] bit_q;
    logic [BYTE_W-1:0]   sh_q;
    logic                scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            ph_q     <= PH_IDLE;
            bit_q    <= '0;
            sh_q     <= '0;
            sda_pull <= 1'b0;
            byte_v   <= 1'b0;
            byte_d   <= '0;
        end else begin
            scl_q  <= scl_f;
            sda_q  <= sda_f;
            byte_v <= 1'b0;
            if (start_c) begin
                ph_q     <= PH_ADDR;
                bit_q    <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                ph_q     <= PH_IDLE;
                bit_q    <= '0;
                sda_pull <= 1'b0;
            end else if (ph_q != PH_IDLE) begin
                if (scl_rise && bit_q < LAST_BIT) begin
                    sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
                    bit_q <= bit_q + 1'b1;
                end else if (scl_fall && bit_q == LAST_BIT) begin
                    if (ph_q == PH_ADDR) begin
                        if (sh_q == own_addr) begin
                            sda_pull <= 1'b1;
                            bit_q    <= ACK_BIT;
                        end else begin
                            ph_q  <= PH_IDLE;
                            bit_q <= '0;
                        end
                    end else begin
                        sda_pull <= 1'b1;
                        bit_q    <= ACK_BIT;
                        byte_v   <= 1'b1;
                        byte_d   <= sh_q;
                    end
                end else if (scl_fall && bit_q == ACK_BIT) begin
                    sda_pull <= 1'b0;
                    bit_q    <= '0;
                    ph_q     <= PH_DATA;
                end
            end
        end
    end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_v,
    input  logic [BYTE_W-1:0] byte_d,
    output regs_t             regs
);
    regs_t nxt;
    sel_e  sel;

    assign sel = sel_e'(byte_d[BYTE_W-1 -: SEL_W]);

    always_comb begin
        nxt = regs;
        case (sel)
            SEL_ATTEN:   nxt.atten = byte_d[2:0];
            SEL_BASS:    if (tone_ok(byte_d[3:0])) nxt.bass = byte_d[3:0];
            SEL_TREBLE:  if (tone_ok(byte_d[3:0])) nxt.treble = byte_d[3:0];
            SEL_VOL_R:   nxt.vol_r = byte_d[4:0];
            SEL_VOL_L:   nxt.vol_l = byte_d[4:0];
            SEL_MIC_CFG: begin
                if (byte_d[1:0] != GAIN_BAD) begin
                    nxt.mic_sel  = byte_d[3:2];
                    nxt.mic_gain = byte_d[1:0];
                end
            end
            SEL_MIC_VOL: nxt.mic_vol = (byte_d[4:0] > MIC_MUTE) ? MIC_MUTE : byte_d[4:0];
            SEL_GENERAL: nxt.gen = gen_t'(byte_d[4:0]);
            default:     nxt = regs;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            regs <= regs_default();
        end else if (byte_v) begin
            regs <= nxt;
        end
    end
endmodule

// File: rtl/cmdbyte_ctl.sv
module cmdbyte_ctl
    import ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       strap_a2_i,
    input  logic       strap_a1_i,
    output logic [2:0] atten_o,
    output logic [3:0] bass_o,
    output logic [3:0] treble_o,
    output logic [4:0] vol_l_o,
    output logic [4:0] vol_r_o,
    output logic       mute_l_o,
    output logic       mute_r_o,
    output logic [1:0] mic_sel_o,
    output logic [1:0] mic_gain_o,
    output logic [4:0] mic_vol_o,
    output logic       mic_mute_o,
    output logic       shutdown_o,
    output logic       gpo_o,
    output logic       enhance_o,
    output logic       mono_o,
    output logic       ext_loop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0]  raw_l, filt_l;
    logic              scl_f, sda_f;
    logic              byte_v;
    logic [BYTE_W-1:0] byte_d;
    regs_t             regs;

    assign raw_l = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        ctl_bus_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_l[g]),
            .dout(filt_l[g])
        );
    end

    assign scl_f = filt_l[0];
    assign sda_f = filt_l[1];

    ctl_i2c_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .own_addr(write_addr(strap_a2_i, strap_a1_i)),
        .sda_pull(sda_pull_o),
        .byte_v  (byte_v),
        .byte_d  (byte_d)
    );

    ctl_reg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .byte_v(byte_v),
        .byte_d(byte_d),
        .regs  (regs)
    );

    assign atten_o    = regs.atten;
    assign bass_o     = regs.bass;
    assign treble_o   = regs.treble;
    assign vol_l_o    = regs.vol_l;
    assign vol_r_o    = regs.vol_r;
    assign mute_l_o   = (regs.vol_l == VOL_MUTE);
    assign mute_r_o   = (regs.vol_r == VOL_MUTE);
    assign mic_sel_o  = regs.mic_sel;
    assign mic_gain_o = regs.mic_gain;
    assign mic_vol_o  = regs.mic_vol;
    assign mic_mute_o = (regs.mic_vol == MIC_MUTE);
    assign shutdown_o = regs.gen.shutdown;
    assign gpo_o      = regs.gen.gpo;
    assign enhance_o  = regs.gen.enhance;
    assign mono_o     = regs.gen.mono;
    assign ext_loop_o = regs.gen.ext_loop;
endmodule

// File: rtl/cmdbyte_ctl_chk.sv
module cmdbyte_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       sda_pull_o,
    input logic       byte_v,
    input logic [2:0] atten_o,
    input logic [3:0] bass_o,
    input logic [3:0] treble_o,
    input logic [4:0] vol_l_o,
    input logic [4:0] vol_r_o,
    input logic [1:0] mic_sel_o,
    input logic [1:0] mic_gain_o,
    input logic [4:0] mic_vol_o,
    input logic [4:0] gen_o
);
    // R3: the pull request only moves while the filtered clock is low
    a_r3_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_f);

    // R5: without a completed byte, no register changes
    a_r5_hold_without_byte: assert property (@(posedge clk) disable iff (rst)
        !byte_v |=> $stable({atten_o, bass_o, treble_o, vol_l_o, vol_r_o,
                             mic_sel_o, mic_gain_o, mic_vol_o, gen_o}));

    // R8: tone codes never leave the legal range
    a_r8_tone_range: assert property (@(posedge clk) disable iff (rst)
        (bass_o <= 4'd12) && (treble_o <= 4'd12));

    // R10: mic level never exceeds the mute code
    a_r10_micvol_range: assert property (@(posedge clk) disable iff (rst)
        mic_vol_o <= 5'd21);

    // R11: reserved gain code never stored
    a_r11_gain_legal: assert property (@(posedge clk) disable iff (rst)
        mic_gain_o != 2'b11);
endmodule

bind cmdbyte_ctl cmdbyte_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_pull_o(sda_pull_o),
    .byte_v    (byte_v),
    .atten_o   (atten_o),
    .bass_o    (bass_o),
    .treble_o  (treble_o),
    .vol_l_o   (vol_l_o),
    .vol_r_o   (vol_r_o),
    .mic_sel_o (mic_sel_o),
    .mic_gain_o(mic_gain_o),
    .mic_vol_o (mic_vol_o),
    .gen_o     ({ext_loop_o, mono_o, enhance_o, gpo_o, shutdown_o})
);

// File: tb/tb_cmdbyte_ctl.sv
module tb_cmdbyte_ctl;
    localparam int HP = 20;
    localparam int WD = 150000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, m_scl, m_sda, a2, a1;
    logic       sda_pull, sda_line;
    logic [2:0] atten;
    logic [3:0] bass, treble;
    logic [4:0] vol_l, vol_r, mic_vol;
    logic       mute_l, mute_r, mic_mute;
    logic [1:0] mic_sel, mic_gain;
    logic       shutdown, gpo, enhance, mono, ext_loop;

    assign sda_line = m_sda & ~sda_pull;

    cmdbyte_ctl dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .strap_a2_i(a2), .strap_a1_i(a1), .atten_o(atten), .bass_o(bass),
        .treble_o(treble), .vol_l_o(vol_l), .vol_r_o(vol_r), .mute_l_o(mute_l),
        .mute_r_o(mute_r), .mic_sel_o(mic_sel), .mic_gain_o(mic_gain),
        .mic_vol_o(mic_vol), .mic_mute_o(mic_mute), .shutdown_o(shutdown),
        .gpo_o(gpo), .enhance_o(enhance), .mono_o(mono), .ext_loop_o(ext_loop)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; waitc(HP);
        m_sda = 1'b0; waitc(HP);
        m_scl = 1'b0; waitc(HP);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitc(HP);
        m_scl = 1'b1; waitc(HP);
        m_sda = 1'b1; waitc(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        bit s0, s1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; waitc(HP);
            m_scl = 1'b1;
            if (glitch && i == 7) begin
                waitc(HP / 2); m_sda = ~b[i]; waitc(1); m_sda = b[i]; waitc(HP - HP / 2 - 1);
            end else begin
                waitc(HP);
            end
            m_scl = 1'b0; waitc(HP / 2);
        end
        m_sda = 1'b1; waitc(HP);
        m_scl = 1'b1; waitc(2);
        s0 = (sda_line == 1'b0);
        waitc(HP - 4);
        s1 = (sda_line == 1'b0);
        waitc(2);
        m_scl = 1'b0; waitc(HP);
        ack = s0 && s1;
    endtask

    task automatic t_reset();
        chk("R4 atten", atten, 0);
        chk("R4 bass", bass, 6);
        chk("R4 treble", treble, 6);
        chk("R4 vol_l", vol_l, 31);
        chk("R4 vol_r", vol_r, 31);
        chk("R4 mutes", {mute_l, mute_r, mic_mute}, 7);
        chk("R4 mic_sel", mic_sel, 0);
        chk("R4 mic_gain", mic_gain, 2);
        chk("R4 mic_vol", mic_vol, 21);
        chk("R4 general", {ext_loop, mono, enhance, gpo, shutdown}, 0);
        chk("R4 no pull", sda_pull, 0);
    endtask

    task automatic t_stream();
        bit ack;
        bus_start();
        send_byte(8'h84, 1'b0, ack); chk("R1 address ack", ack, 1);
        send_byte(8'b000_11_101, 1'b0, ack); chk("R3 data ack", ack, 1);
        send_byte(8'h29, 1'b0, ack); chk("R6 second byte ack", ack, 1);
        send_byte(8'h43, 1'b0, ack); chk("R6 third byte ack", ack, 1);
        chk("R3 released after ack", sda_pull, 0);
        bus_stop();
        chk("R7 atten low bits only", atten, 5);
        chk("R6 bass applied", bass, 9);
        chk("R6 treble applied", treble, 3);
        chk("R5 left level untouched", vol_l, 31);
        chk("R5 mic untouched", mic_vol, 21);
    endtask

    task automatic t_levels();
        bit ack;
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'h80 | 8'd4, 1'b0, ack);
        send_byte(8'h60 | 8'd31, 1'b0, ack);
        bus_stop();
        chk("R9 left level", vol_l, 4);
        chk("R9 left unmuted", mute_l, 0);
        chk("R9 right mute flag", mute_r, 1);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'h60 | 8'd30, 1'b0, ack);
        bus_stop();
        chk("R9 right level 30", vol_r, 30);
        chk("R9 right unmuted", mute_r, 0);
        chk("R5 left kept", vol_l, 4);
    endtask

    task automatic t_tone_illegal();
        bit ack;
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'h2D, 1'b0, ack); chk("R8 code 13 acked", ack, 1);
        send_byte(8'h4F, 1'b0, ack); chk("R8 code 15 acked", ack, 1);
        bus_stop();
        chk("R8 bass kept", bass, 9);
        chk("R8 treble kept", treble, 3);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'h2C, 1'b0, ack);
        bus_stop();
        chk("R8 bass code 12", bass, 12);
    endtask

    task automatic t_mic();
        bit ack;
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hA5, 1'b0, ack);
        bus_stop();
        chk("R11 mic select input 2", mic_sel, 1);
        chk("R11 mic gain 20dB", mic_gain, 1);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hAB, 1'b0, ack); chk("R11 reserved gain acked", ack, 1);
        bus_stop();
        chk("R11 select kept", mic_sel, 1);
        chk("R11 gain kept", mic_gain, 1);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hC0 | 8'd3, 1'b0, ack);
        bus_stop();
        chk("R10 mic level 3", mic_vol, 3);
        chk("R10 mic unmuted", mic_mute, 0);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hC0 | 8'd25, 1'b0, ack);
        bus_stop();
        chk("R10 clamp to 21", mic_vol, 21);
        chk("R10 mic muted", mic_mute, 1);
    endtask

    task automatic t_general();
        bit ack;
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hE0 | 8'b10101, 1'b0, ack);
        bus_stop();
        chk("R12 shutdown bit0", shutdown, 1);
        chk("R12 gpo bit1", gpo, 0);
        chk("R12 enhance bit2", enhance, 1);
        chk("R12 mono bit3", mono, 0);
        chk("R12 loop bit4", ext_loop, 1);
        bus_start();
        send_byte(8'h84, 1'b0, ack);
        send_byte(8'hE0 | 8'b01010, 1'b0, ack);
        bus_stop();
        chk("R12 pattern 01010", {ext_loop, mono, enhance, gpo, shutdown}, 10);
    endtask

    task automatic t_bad_address();
        bit ack;
        bus_start();
        send_byte(8'h86, 1'b0, ack); chk("R1 wrong address nak", ack, 0);
        send_byte(8'h00, 1'b0, ack); chk("R1 no ack after nak", ack, 0);
        bus_stop();
        chk("R1 atten unchanged", atten, 5);
        bus_start();
        send_byte(8'h85, 1'b0, ack); chk("R2 read nak", ack, 0);
        send_byte(8'h01, 1'b0, ack);
        bus_stop();
        chk("R2 atten unchanged", atten, 5);
    endtask

    task automatic t_straps();
        bit ack;
        a2 = 1'b0; a1 = 1'b1; waitc(4);
        bus_start();
        send_byte(8'h84, 1'b0, ack); chk("R1 old address nak", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h82, 1'b0, ack); chk("R1 strap address ack", ack, 1);
        send_byte(8'h02, 1'b0, ack);
        bus_stop();
        chk("R1 strap write", atten, 2);
    endtask

    task automatic t_glitch();
        bit ack;
        bus_start();
        send_byte(8'h82, 1'b0, ack);
        send_byte(8'h07, 1'b1, ack); chk("R13 glitched byte ack", ack, 1);
        send_byte(8'h80 | 8'd9, 1'b0, ack); chk("R13 transfer survives", ack, 1);
        bus_stop();
        chk("R13 atten after glitch", atten, 7);
        chk("R13 left level after glitch", vol_l, 9);
    endtask

    initial begin
        repeat (WD) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1; a2 = 1'b1; a1 = 1'b0;
        waitc(5);
        rst = 1'b0;
        waitc(10);
        t_reset();
        t_stream();
        t_levels();
        t_tone_illegal();
        t_mic();
        t_general();
        t_bad_address();
        t_straps();
        t_glitch();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule